// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Device Model

This block is a synthesizable stand-in for the device end of a three-wire serial EEPROM. A host drives a chip-select line, a shift clock and a serial data line. The block answers on a serial data output and drives a separate output enable, so it can share a bus wire with other devices. All inputs are sampled in the system clock domain, and rising shift-clock edges are found by comparing each sample with the one before. Words are held in a small register array, and one input selects 16-bit or 8-bit word organization over the same storage.

The block decodes seven commands: read, write, erase, erase-all, write-all, enable programming and disable programming. Any command that changes storage is blocked unless a programming-enable latch is set. A programming command starts a self-timed cycle whose length in system clocks is a parameter. While that cycle runs, the block takes no new command. If the host deselects and then reselects the block, the data output reports ready or busy.

Top module: `eep_top`

## Requirements
- R1: While chip select is high, the block samples the data input on each shift-clock rising edge. Zeros before the first 1 are skipped, and that first 1 is the start bit. Two opcode bits follow, then the address, most significant bit first. The address is 6 bits in 16-bit mode and 7 bits in 8-bit mode.
- R2: Read uses opcode 10. On the edge that takes the last address bit, the output enable rises and the data output shows a single 0. Each of the next 16 (or 8) rising edges then presents one data bit, most significant first. Read works whether or not the programming latch is set.
- R3: With org16 high, storage is 64 words of 16 bits. With org16 low, it is 128 bytes, and byte address b selects bits [15:8] of word b>>1 when b[0] is 1 and bits [7:0] when b[0] is 0.
- R4: Reset clears the programming latch. Opcode 00 with the top two address bits at 11 sets the latch. Opcode 00 with the top two address bits at 00 clears it.
- R5: When the programming latch is clear, write, erase, erase-all and write-all change no storage and start no program cycle.
- R6: Write uses opcode 01 and is followed by 16 (or 8) data bits, most significant first. It replaces the addressed word with no erase needed first. Erase uses opcode 11 and sets every bit of the addressed word to 1.
- R7: Erase-all is opcode 00 with the top two address bits at 10, and it sets every bit of storage to 1. Write-all is opcode 00 with the top two address bits at 01, followed by data bits, and it writes that data to every word (in 8-bit mode, to every byte).
- R8: A program cycle lasts PROG_CYCLES system clocks. For write and write-all it starts after the last data bit. For erase and erase-all it starts after the last address bit. After the block is deselected and reselected, the output enable is high while no command is in progress, and the data output reads 0 while the cycle runs and 1 once it has ended. This status stays available until the next start bit is taken.
- R9: A start bit that arrives during a program cycle is ignored, so that command changes nothing.
- R10: Taking chip select low ends any command in progress, and a command cut short this way changes no storage. The output enable is low whenever chip select is low and is low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Chip select, active high |
| sclk | input | 1 | Serial shift clock, sampled by clk |
| sdi | input | 1 | Serial data input |
| org16 | input | 1 | 1 selects 16-bit words, 0 selects 8-bit words |
| sdo | output | 1 | Serial data output or ready/busy flag |
| sdo_oe | output | 1 | Output enable for sdo |

## Verification
The bench first fills storage with known values using erase-all and write-all. Every later "no effect" case then has a defined answer. One read is preceded by leading zeros, which shows that the start bit is taken from the data and not from the chip-select edge. Writes made after a reset, after the disable command, while a program cycle is running, and with chip select dropped partway through are each read back unchanged, which separates the four blocking paths. Words written in 16-bit mode are then read as bytes, and bytes are written and erased in 8-bit mode. This confirms the byte-lane order and shows that the two halves of a word are independent. The busy interval is measured against PROG_CYCLES.

// File: rtl/eep_pkg.sv
`timescale 1ns/1ps
package eep_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPC,
        ST_ADDR,
        ST_DATA,
        ST_READ,
        ST_DONE
    } eep_state_e;

    localparam logic [1:0] OP_EXT   = 2'b00;
    localparam logic [1:0] OP_WRITE = 2'b01;
    localparam logic [1:0] OP_READ  = 2'b10;
    localparam logic [1:0] OP_ERASE = 2'b11;

    localparam logic [1:0] EXT_LOCK  = 2'b00;
    localparam logic [1:0] EXT_FILL  = 2'b01;
    localparam logic [1:0] EXT_CLEAR = 2'b10;
    localparam logic [1:0] EXT_OPEN  = 2'b11;
endpackage

// File: rtl/eep_prog_timer.sv
`timescale 1ns/1ps
module eep_prog_timer #(
    parameter int PROG_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int TW = $clog2(PROG_CYCLES + 1);

    logic [TW-1:0] left_d, left_q;

    always_comb begin
        left_d = left_q;
        if (start) begin
            left_d = TW'(PROG_CYCLES);
        end else if (left_q != '0) begin
            left_d = left_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) left_q <= '0;
        else        left_q <= left_d;
    end

    assign busy = (left_q != '0);
endmodule

// File: rtl/eep_store.sv
`timescale 1ns/1ps
module eep_store #(
    parameter int WORD_AW = 6,
    parameter int DATA_W  = 16
) (
    input  logic               clk,
    input  logic               org16,
    input  logic               wr_one,
    input  logic               wr_all,
    input  logic [WORD_AW:0]   wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [WORD_AW:0]   rd_addr,
    output logic [DATA_W-1:0]  rd_word
);
    localparam int WORDS  = 1 << WORD_AW;
    localparam int BYTE_W = DATA_W / 2;

    logic [DATA_W-1:0]  word_v [WORDS];
    logic [WORD_AW-1:0] tgt_word;
    logic               tgt_hi;
    logic [BYTE_W-1:0]  hi_val, lo_val;

    always_comb begin
        tgt_word = org16 ? wr_addr[WORD_AW-1:0] : wr_addr[WORD_AW:1];
        tgt_hi   = wr_addr[0];
        lo_val   = wr_data[BYTE_W-1:0];
        hi_val   = org16 ? wr_data[DATA_W-1:BYTE_W] : wr_data[BYTE_W-1:0];
    end

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        logic hit, en_hi, en_lo;
        logic [DATA_W-1:0] cell_q;

        assign hit   = wr_one && (tgt_word == WORD_AW'(w));
        assign en_hi = wr_all || (hit && (org16 || tgt_hi));
        assign en_lo = wr_all || (hit && (org16 || !tgt_hi));

        always_ff @(posedge clk) begin
            if (en_hi) cell_q[DATA_W-1:BYTE_W] <= hi_val;
            if (en_lo) cell_q[BYTE_W-1:0]      <= lo_val;
        end

        assign word_v[w] = cell_q;
    end

    logic [DATA_W-1:0] rd_full;

    always_comb begin
        rd_full = word_v[org16 ? rd_addr[WORD_AW-1:0] : rd_addr[WORD_AW:1]];
        if (org16) begin
            rd_word = rd_full;
        end else if (rd_addr[0]) begin
            rd_word = {{BYTE_W{1'b0}}, rd_full[DATA_W-1:BYTE_W]};
        end else begin
            rd_word = {{BYTE_W{1'b0}}, rd_full[BYTE_W-1:0]};
        end
    end
endmodule

// File: rtl/eep_serial_ctrl.sv
`timescale 1ns/1ps
module eep_serial_ctrl
    import eep_pkg::*;
#(
    parameter int WORD_AW = 6,
    parameter int DATA_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs,
    input  logic               sclk,
    input  logic               sdi,
    input  logic               org16,
    input  logic               busy,
    input  logic [DATA_W-1:0]  rd_word,
    output logic [WORD_AW:0]   rd_addr,
    output logic               wr_one,
    output logic               wr_all,
    output logic [WORD_AW:0]   wr_addr,
    output logic [DATA_W-1:0]  wr_data,
    output logic               prog_go,
    output logic               prog_en,
    output logic               sdo,
    output logic               sdo_oe
);
    localparam int BYTE_AW = WORD_AW + 1;
    localparam int BYTE_W  = DATA_W / 2;
    localparam int CNT_MAX = (DATA_W > BYTE_AW) ? DATA_W : BYTE_AW;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    typedef struct packed {
        eep_state_e         state;
        logic [CNT_W-1:0]   cnt;
        logic [1:0]         opc;
        logic [BYTE_AW-1:0] addr;
        logic [DATA_W-1:0]  shreg;
        logic               sdo;
        logic               oe;
        logic               pe;
        logic               stat;
        logic               sclk_prev;
        logic               go;
        logic               wr_one;
        logic               wr_all;
        logic [BYTE_AW-1:0] wr_addr;
        logic [DATA_W-1:0]  wr_data;
    } ctrl_t;

    ctrl_t q, d;

    logic               rise;
    logic [BYTE_AW-1:0] a_next;
    logic [DATA_W-1:0]  s_next;
    logic [1:0]         top2;
    logic [CNT_W-1:0]   aw_last, dw_last, bit_idx;

    always_comb begin
        d            = q;
        d.sclk_prev  = sclk;
        d.go         = 1'b0;
        d.wr_one     = 1'b0;
        d.wr_all     = 1'b0;

        rise    = sclk & ~q.sclk_prev;
        a_next  = {q.addr[BYTE_AW-2:0], sdi};
        s_next  = {q.shreg[DATA_W-2:0], sdi};
        top2    = org16 ? a_next[WORD_AW-1 -: 2] : a_next[BYTE_AW-1 -: 2];
        aw_last = org16 ? CNT_W'(WORD_AW - 1) : CNT_W'(BYTE_AW - 1);
        dw_last = org16 ? CNT_W'(DATA_W - 1) : CNT_W'(BYTE_W - 1);
        bit_idx = dw_last - q.cnt;

        if (!cs) begin
            d.state = ST_IDLE;
            d.oe    = 1'b0;
            d.cnt   = '0;
        end else if (rise) begin
            case (q.state)
                ST_IDLE: begin
                    if (sdi && !busy) begin
                        d.state = ST_OPC;
                        d.cnt   = '0;
                        d.addr  = '0;
                        d.stat  = 1'b0;
                    end
                end
                ST_OPC: begin
                    d.opc = {q.opc[0], sdi};
                    if (q.cnt == CNT_W'(1)) begin
                        d.state = ST_ADDR;
                        d.cnt   = '0;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                ST_ADDR: begin
                    d.addr = a_next;
                    d.cnt  = q.cnt + 1'b1;
                    if (q.cnt == aw_last) begin
                        d.cnt     = '0;
                        d.state   = ST_DONE;
                        d.wr_addr = a_next;
                        d.shreg   = '0;
                        case (q.opc)
                            OP_READ: begin
                                d.state = ST_READ;
                                d.oe    = 1'b1;
                                d.sdo   = 1'b0;
                            end
                            OP_WRITE: d.state = ST_DATA;
                            OP_ERASE: begin
                                if (q.pe) begin
                                    d.go      = 1'b1;
                                    d.wr_one  = 1'b1;
                                    d.wr_data = '1;
                                    d.stat    = 1'b1;
                                end
                            end
                            default: begin
                                case (top2)
                                    EXT_OPEN: d.pe = 1'b1;
                                    EXT_LOCK: d.pe = 1'b0;
                                    EXT_CLEAR: begin
                                        if (q.pe) begin
                                            d.go      = 1'b1;
                                            d.wr_all  = 1'b1;
                                            d.wr_data = '1;
                                            d.stat    = 1'b1;
                                        end
                                    end
                                    default: d.state = ST_DATA;
                                endcase
                            end
                        endcase
                    end
                end
                ST_DATA: begin
                    d.shreg = s_next;
                    d.cnt   = q.cnt + 1'b1;
                    if (q.cnt == dw_last) begin
                        d.state = ST_DONE;
                        d.cnt   = '0;
                        if (q.pe) begin
                            d.go      = 1'b1;
                            d.stat    = 1'b1;
                            d.wr_data = s_next;
                            if (q.opc == OP_WRITE) d.wr_one = 1'b1;
                            else                   d.wr_all = 1'b1;
                        end
                    end
                end
                ST_READ: begin
                    if (q.cnt > dw_last) begin
                        d.oe    = 1'b0;
                        d.state = ST_DONE;
                    end else begin
                        d.sdo = rd_word[bit_idx];
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rd_addr = q.addr;
    assign wr_one  = q.wr_one;
    assign wr_all  = q.wr_all;
    assign wr_addr = q.wr_addr;
    assign wr_data = q.wr_data;
    assign prog_go = q.go;
    assign prog_en = q.pe;
    assign sdo_oe  = cs && (q.oe || ((q.state == ST_IDLE) && q.stat));
    assign sdo     = q.oe ? q.sdo : ~busy;
endmodule

// File: rtl/eep_top.sv
`timescale 1ns/1ps
module eep_top #(
    parameter int WORD_AW     = 6,
    parameter int DATA_W      = 16,
    parameter int PROG_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic sclk,
    input  logic sdi,
    input  logic org16,
    output logic sdo,
    output logic sdo_oe
);
    logic              prog_go, prog_busy, prog_en;
    logic              wr_one, wr_all;
    logic [WORD_AW:0]  wr_addr, rd_addr;
    logic [DATA_W-1:0] wr_data, rd_word;

    eep_serial_ctrl #(.WORD_AW(WORD_AW), .DATA_W(DATA_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs      (cs),
        .sclk    (sclk),
        .sdi     (sdi),
        .org16   (org16),
        .busy    (prog_busy),
        .rd_word (rd_word),
        .rd_addr (rd_addr),
        .wr_one  (wr_one),
        .wr_all  (wr_all),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .prog_go (prog_go),
        .prog_en (prog_en),
        .sdo     (sdo),
        .sdo_oe  (sdo_oe)
    );

    eep_store #(.WORD_AW(WORD_AW), .DATA_W(DATA_W)) u_store (
        .clk     (clk),
        .org16   (org16),
        .wr_one  (wr_one),
        .wr_all  (wr_all),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_word (rd_word)
    );

    eep_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (prog_go),
        .busy  (prog_busy)
    );
endmodule

// File: rtl/eep_chk.sv
`timescale 1ns/1ps
module eep_chk (
    input logic clk,
    input logic rst_n,
    input logic cs,
    input logic sdo_oe,
    input logic pe,
    input logic go,
    input logic busy,
    input logic wr_one,
    input logic wr_all
);
    assert_oe_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |-> !sdo_oe);

    assert_locked_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_one || wr_all) |-> pe);

    assert_write_starts_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_one || wr_all) |-> go);

    assert_timer_follows_go_R8: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> busy);

    assert_busy_has_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(go));

    assert_no_go_while_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> !busy);
endmodule

bind eep_top eep_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .cs     (cs),
    .sdo_oe (sdo_oe),
    .pe     (prog_en),
    .go     (prog_go),
    .busy   (prog_busy),
    .wr_one (wr_one),
    .wr_all (wr_all)
);

// File: tb/tb_eep_top.sv
`timescale 1ns/1ps
module tb_eep_top;
    localparam int AW   = 6;
    localparam int DW   = 16;
    localparam int PC   = 1000;
    localparam int HALF = 4;

    logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sclk = 1'b0, sdi = 1'b0, org16 = 1'b1;
    logic sdo, sdo_oe;

    eep_top #(.WORD_AW(AW), .DATA_W(DW), .PROG_CYCLES(PC)) dut (
        .clk(clk), .rst_n(rst_n), .cs(cs), .sclk(sclk), .sdi(sdi),
        .org16(org16), .sdo(sdo), .sdo_oe(sdo_oe)
    );

    always #2.5 clk = ~clk;

    int checks = 0, fails = 0;
    logic [15:0] model [64];

    typedef struct { string tag; logic [15:0] val; } item_t;
    item_t exp_q[$];
    item_t act_q[$];

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int awid(); return org16 ? 6 : 7; endfunction
    function automatic int dwid(); return org16 ? 16 : 8; endfunction

    function automatic logic [15:0] exp_at(int a);
        if (org16) return model[a];
        return a[0] ? {8'h00, model[a >> 1][15:8]} : {8'h00, model[a >> 1][7:0]};
    endfunction

    task automatic pulse(logic b);
        sdi = b; sclk = 1'b0; tick(HALF);
        sclk = 1'b1; tick(HALF);
    endtask

    task automatic send(int lead, logic [1:0] op, int addr);
        cs = 1'b1; tick(2);
        repeat (lead) pulse(1'b0);
        pulse(1'b1); pulse(op[1]); pulse(op[0]);
        for (int i = awid() - 1; i >= 0; i--) pulse(addr[i]);
    endtask

    task automatic send_data(logic [15:0] v);
        for (int i = dwid() - 1; i >= 0; i--) pulse(v[i]);
    endtask

    task automatic deselect();
        sclk = 1'b0; sdi = 1'b0; tick(2);
        cs = 1'b0; tick(3);
    endtask

    task automatic wait_ready(string tag);
        int n = 0;
        cs = 1'b1; tick(2);
        while (sdo !== 1'b1 && n < 5 * PC) begin tick(1); n++; end
        chk(tag, {31'd0, sdo_oe && sdo}, 32'd1);
        cs = 1'b0; tick(3);
    endtask

    task automatic no_status(string tag);
        cs = 1'b1; tick(2);
        chk(tag, {31'd0, sdo_oe}, 32'd0);
        cs = 1'b0; tick(3);
    endtask

    function automatic int ext(logic [1:0] t);
        return int'(t) << (awid() - 2);
    endfunction

    task automatic cmd_open();  send(0, 2'b00, ext(2'b11)); deselect(); endtask
    task automatic cmd_lock();  send(0, 2'b00, ext(2'b00)); deselect(); endtask

    task automatic do_write(int a, logic [15:0] v);
        send(0, 2'b01, a); send_data(v); deselect();
        wait_ready("R8 ready after write");
    endtask

    task automatic do_read(string tag, int lead, int a);
        item_t e, g;
        logic [15:0] got = '0;
        e.tag = tag; e.val = exp_at(a);
        exp_q.push_back(e);
        send(lead, 2'b10, a);
        chk({tag, " dummy"}, {30'd0, sdo_oe, sdo}, 32'd2);
        for (int i = 0; i < dwid(); i++) begin
            pulse(1'b0);
            got = {got[14:0], sdo};
        end
        deselect();
        g.tag = tag; g.val = got;
        act_q.push_back(g);
    endtask

    initial begin : monitor
        forever begin
            item_t a, e;
            wait (act_q.size() > 0);
            a = act_q.pop_front();
            e = exp_q.pop_front();
            chk(e.tag, {16'd0, a.val}, {16'd0, e.val});
        end
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin : main
        int n;
        tick(5);
        chk("R10 reset oe", {31'd0, sdo_oe}, 32'd0);
        rst_n = 1'b1; tick(3);

        // fill with ones so blocked writes have a defined answer (R7)
        cmd_open();
        send(0, 2'b00, ext(2'b10)); deselect();
        wait_ready("R7 erase-all ready");
        for (int i = 0; i < 64; i++) model[i] = 16'hFFFF;
        do_read("R7 erase-all word 9", 0, 9);

        // reset clears latch (R4), blocked write (R5)
        rst_n = 1'b0; tick(3); rst_n = 1'b1; tick(3);
        send(0, 2'b01, 5); send_data(16'h1234); deselect();
        no_status("R5 no cycle after reset");
        do_read("R4 R5 write after reset blocked", 0, 5);

        // write with cycle timing (R6, R8)
        cmd_open();
        send(0, 2'b01, 5); send_data(16'h1234); deselect();
        cs = 1'b1; tick(1);
        chk("R8 busy flag", {30'd0, sdo_oe, sdo}, 32'd2);
        n = 0;
        while (sdo !== 1'b1 && n < 5 * PC) begin tick(1); n++; end
        chk("R8 cycle length", {31'd0, (n >= PC - 15) && (n <= PC - 5)}, 32'd1);
        tick(4);
        chk("R8 ready held", {30'd0, sdo_oe, sdo}, 32'd3);
        cs = 1'b0; tick(3);
        model[5] = 16'h1234;
        do_read("R2 R6 read word 5", 0, 5);
        do_write(63, 16'hBEEF); model[63] = 16'hBEEF;
        do_write(0, 16'h8001);  model[0] = 16'h8001;
        do_read("R1 lead zeros word 63", 3, 63);
        do_read("R2 read word 0", 0, 0);

        // erase and overwrite (R6)
        send(0, 2'b11, 5); deselect();
        wait_ready("R8 ready after erase");
        model[5] = 16'hFFFF;
        do_read("R6 erase word 5", 0, 5);
        do_write(63, 16'h0F0F); model[63] = 16'h0F0F;
        do_read("R6 overwrite word 63", 0, 63);

        // command during busy is ignored (R9)
        send(0, 2'b01, 10); send_data(16'hAAAA); deselect();
        send(0, 2'b01, 11); send_data(16'h5555); deselect();
        wait_ready("R9 ready");
        model[10] = 16'hAAAA;
        do_read("R9 busy write ignored", 0, 11);
        do_read("R6 word 10", 0, 10);

        // aborted command (R10)
        send(0, 2'b01, 12); for (int i = 0; i < 8; i++) pulse(1'b1); deselect();
        no_status("R10 abort no cycle");
        do_read("R10 abort no change", 0, 12);

        // write-all (R7)
        send(0, 2'b00, ext(2'b01)); send_data(16'h3C3C); deselect();
        wait_ready("R7 write-all ready");
        for (int i = 0; i < 64; i++) model[i] = 16'h3C3C;
        do_read("R7 write-all word 0", 0, 0);
        do_read("R7 write-all word 63", 0, 63);

        // byte organization (R3)
        do_write(7, 16'hA55A); model[7] = 16'hA55A;
        org16 = 1'b0; tick(2);
        do_read("R3 byte 14 low", 0, 14);
        do_read("R3 byte 15 high", 0, 15);
        do_write(20, 16'h0077); model[10][7:0] = 8'h77;
        do_read("R3 byte 20", 0, 20);
        send(0, 2'b11, 21); deselect();
        wait_ready("R8 ready after byte erase");
        model[10][15:8] = 8'hFF;
        send(0, 2'b00, ext(2'b01)); send_data(16'h00C3); deselect();
        wait_ready("R7 byte write-all ready");
        for (int i = 0; i < 64; i++) model[i] = 16'hC3C3;
        do_read("R7 byte write-all byte 33", 0, 33);

        // disable command (R4, R5) in byte mode, read still works (R2)
        cmd_lock();
        send(0, 2'b01, 40); send_data(16'h0011); deselect();
        no_status("R5 locked write no cycle");
        do_read("R4 R5 locked byte 40", 0, 40);
        org16 = 1'b1; tick(2);
        send(0, 2'b00, ext(2'b10)); deselect();
        no_status("R5 locked erase-all no cycle");
        do_read("R2 R5 read while locked", 0, 3);

        tick(20);
        chk("scoreboard drained", act_q.size() + exp_q.size(), 0);
        summary();
        $finish;
    end
endmodule